// File: doc/BRIEF.md
# Serial Channel Setup-Request Decoder

This block sits behind the control endpoint of a USB serial bridge. It takes the fields of a SETUP stage (request type, request code, value and index) and turns each accepted request into an update of a per-channel serial configuration set. That set holds the modem-control outputs, the flow-control modes and their XON/XOFF characters, the data format, the break state, the event and error characters, the latency timer, the bit mode and the baud divisor. Read requests return modem and line status, the latency timer or the raw pin state. A reset request can pulse purge strobes toward the channel's receive (IN) and transmit (OUT) buffers.

Each request is presented for one cycle on `setup_vld`. In the next cycle the block reports `resp_vld` with either a stall (request refused, no register touched) or the response length and data. The number of channels is a parameter. A single-channel build addresses its channel as 0. A multi-channel build numbers its channels from 1, as interface index plus one. EEPROM word writes elsewhere in the device are gated by `ee_wr_en`, which is high only while the channel's latency timer holds the unlock value 0x77.

Top module: `usbctl_vreq`

## Requirements
- R1: Set requests (codes 0x00 reset, 0x01 modem control, 0x02 flow control, 0x03 baud, 0x04 data format, 0x06 event char, 0x07 error char, 0x09 set latency, 0x0B bit mode) are accepted only with request type 0x40. Get requests (0x05 modem status, 0x0A get latency, 0x0C pin state) are accepted only with 0xC0. Any other code, a type mismatch, or a reset kind above 2 is stalled and changes no register.
- R2: `resp_vld` is high for the cycle after each `setup_vld`. Accepted set requests answer with length 0. Get latency returns length 1 with the latency in data[7:0]. Pin state returns length 1 with the channel's `pin_in` byte. Modem status returns length 2: data[7:0] = {DCD, RI, DSR, CTS, 4'b0001}, taken from `modem_in` bits {3,2,1,0}, and data[15:8] = the channel's `line_stat`.
- R3: Modem control sets DTR from value bit 0 only when value bit 8 is set, and RTS from value bit 1 only when value bit 9 is set. Otherwise the line keeps its state.
- R4: Flow control loads XON from value[7:0] and XOFF from value[15:8]. It sets `flow_mode` bit 0 (RTS/CTS), bit 1 (DTR/DSR) and bit 2 (XON/XOFF) from index bits 8, 9 and 10.
- R5: Data format loads data bits from value[7:0], parity from value[10:8], stop bits from value[13:11] and break from value[14].
- R6: Event and error character requests load the character from value[7:0] and its enable from value[8].
- R7: Reset kind 0 pulses both purge strobes for one cycle, sets the event character to 0x0D with its enable cleared, clears all flow modes, and clears DTR and RTS. Kind 1 pulses only `purge_out`. Kind 2 pulses only `purge_in`. Other settings are kept.
- R8: The latency timer leaves reset at 16. A write with a value in 2..255 is stored as is. Any other value is stored as 2.
- R9: `ee_wr_en` of a channel is high exactly while its latency timer holds 0x77.
- R10: In a multi-channel build, index[7:0] values 1..NUM_CH select channel value-1, and any other value stalls. In a single-channel build, index[7:0] must be 0, except for the baud request.
- R11: The baud request stores an 18-bit divisor: value as bits 15:0, and bits 17:16 taken from index[9:8] in a multi-channel build or from index[1:0] in a single-channel build.
- R12: Bit mode stores value[15:8] as the mode and value[7:0] as the pin direction mask.
- R13: After reset: no response and no purge pulses, DTR/RTS low, data bits 8, event character 0x0D disabled, latency 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_vld | input | 1 | One-cycle strobe: a SETUP request is present |
| req_type | input | 8 | Request type byte |
| req_code | input | 8 | Request code byte |
| req_val | input | 16 | Request value field |
| req_idx | input | 16 | Request index field |
| modem_in | input | 4*NUM_CH | Per channel {DCD, RI, DSR, CTS} |
| line_stat | input | 8*NUM_CH | Per channel line status byte |
| pin_in | input | 8*NUM_CH | Per channel raw pin state |
| resp_vld | output | 1 | Response present |
| resp_stall | output | 1 | Request refused |
| resp_len | output | 2 | Response data length in bytes |
| resp_data | output | 16 | Response data, first byte in [7:0] |
| purge_in | output | NUM_CH | One-cycle receive-buffer purge |
| purge_out | output | NUM_CH | One-cycle transmit-buffer purge |
| modem_dtr | output | NUM_CH | DTR output state |
| modem_rts | output | NUM_CH | RTS output state |
| flow_mode | output | 3*NUM_CH | {XON/XOFF, DTR/DSR, RTS/CTS} enables |
| xon_char | output | 8*NUM_CH | XON character |
| xoff_char | output | 8*NUM_CH | XOFF character |
| data_bits | output | 8*NUM_CH | Data bit count |
| parity_sel | output | 3*NUM_CH | Parity mode |
| stop_sel | output | 3*NUM_CH | Stop bit mode |
| brk_on | output | NUM_CH | Break forced |
| evt_char | output | 8*NUM_CH | Event character |
| evt_en | output | NUM_CH | Event character enable |
| err_char | output | 8*NUM_CH | Error character |
| err_en | output | NUM_CH | Error character enable |
| lat_ms | output | 8*NUM_CH | Latency timer in ms |
| bit_mode | output | 8*NUM_CH | Bit mode |
| bit_mask | output | 8*NUM_CH | Bit mode pin direction mask |
| baud_div | output | 18*NUM_CH | Baud divisor |
| ee_wr_en | output | NUM_CH | EEPROM write permitted |

## Verification
A table of requests drives a two-channel build. It contains accepted reads and writes, unknown codes, codes sent with the wrong direction type, reset kinds out of range, and channel numbers 0 and NUM_CH+1. These show whether the stall rule looks at the code, the type and the channel together, and the follow-up latency reads show that a refused request left the registers as they were. Directed sequences check the masked DTR/RTS update with each change bit alone and with neither, and the three reset kinds with their distinct purge patterns and default reloads. They also cover the latency clamp at 1 and 256 and the 0x77 unlock. A single-channel instance checks channel 0 addressing and the baud request, whose index low bits carry divisor bits rather than a channel number.

// File: rtl/usbctl_pkg.sv
package usbctl_pkg;

    localparam logic [7:0] TYPE_SET = 8'h40;
    localparam logic [7:0] TYPE_GET = 8'hC0;
    localparam logic [7:0] LAT_DEF  = 8'd16;
    localparam logic [7:0] LAT_MIN  = 8'd2;
    localparam logic [7:0] LAT_KEY  = 8'h77;
    localparam logic [7:0] EVT_DEF  = 8'h0D;

    typedef enum logic [7:0] {
        RQ_RESET = 8'h00,
        RQ_MODEM = 8'h01,
        RQ_FLOW  = 8'h02,
        RQ_BAUD  = 8'h03,
        RQ_FMT   = 8'h04,
        RQ_MSTAT = 8'h05,
        RQ_EVT   = 8'h06,
        RQ_ERR   = 8'h07,
        RQ_LATW  = 8'h09,
        RQ_LATR  = 8'h0A,
        RQ_BMODE = 8'h0B,
        RQ_PINS  = 8'h0C
    } req_e;

    typedef struct packed {
        logic        dtr;
        logic        rts;
        logic [2:0]  flow;
        logic [7:0]  xon;
        logic [7:0]  xoff;
        logic [7:0]  dbits;
        logic [2:0]  par;
        logic [2:0]  stop;
        logic        brk;
        logic [7:0]  evt;
        logic        evt_en;
        logic [7:0]  err;
        logic        err_en;
        logic [7:0]  lat;
        logic [7:0]  bmode;
        logic [7:0]  bmask;
        logic [17:0] baud;
    } chan_cfg_t;

    function automatic logic code_known(input logic [7:0] c);
        return c inside {RQ_RESET, RQ_MODEM, RQ_FLOW, RQ_BAUD, RQ_FMT, RQ_MSTAT,
                         RQ_EVT, RQ_ERR, RQ_LATW, RQ_LATR, RQ_BMODE, RQ_PINS};
    endfunction

    function automatic logic code_is_get(input logic [7:0] c);
        return c inside {RQ_MSTAT, RQ_LATR, RQ_PINS};
    endfunction

endpackage

// File: rtl/usbctl_decode.sv
module usbctl_decode
    import usbctl_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_vld,
    input  logic [7:0]        req_type,
    input  logic [7:0]        req_code,
    input  logic [15:0]       req_val,
    input  logic [15:0]       req_idx,
    output logic              good,
    output logic              stall,
    output logic [NUM_CH-1:0] wr_sel,
    output logic [CW-1:0]     ch_num,
    output logic [1:0]        baud_hi
);
    localparam bit MULTI = (NUM_CH > 1);

    logic       dir_ok, kind_ok, ch_ok;
    logic [7:0] ch_raw;
    logic [4:0] unused_idx;

    assign unused_idx = req_idx[15:11];

    always_comb begin
        dir_ok  = code_is_get(req_code) ? (req_type == TYPE_GET) : (req_type == TYPE_SET);
        kind_ok = (req_code != RQ_RESET) || (req_val <= 16'd2);
        ch_raw  = req_idx[7:0] - 8'd1;
        if (MULTI) begin
            ch_ok   = (req_idx[7:0] >= 8'd1) && (req_idx[7:0] <= 8'(NUM_CH));
            ch_num  = ch_raw[CW-1:0];
            baud_hi = req_idx[9:8];
        end else begin
            ch_ok   = (req_code == RQ_BAUD) || (req_idx[7:0] == 8'd0);
            ch_num  = '0;
            baud_hi = req_idx[1:0];
        end
        good   = setup_vld && code_known(req_code) && dir_ok && kind_ok && ch_ok;
        stall  = setup_vld && !good;
        wr_sel = '0;
        if (good && !code_is_get(req_code))
            wr_sel[ch_num] = 1'b1;
    end

    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
    assert_stall_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (wr_sel == '0));

endmodule

// File: rtl/usbctl_chan.sv
module usbctl_chan
    import usbctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [7:0]  code,
    input  logic [15:0] val,
    input  logic [2:0]  flow_in,
    input  logic [1:0]  baud_hi,
    output chan_cfg_t   cfg,
    output logic        purge_in,
    output logic        purge_out
);
    typedef struct packed {
        chan_cfg_t cfg;
        logic      pin;
        logic      pout;
    } st_t;

    st_t st_d, st_q;

    function automatic chan_cfg_t cfg_reset();
        chan_cfg_t c;
        c       = '0;
        c.dbits = 8'd8;
        c.evt   = EVT_DEF;
        c.lat   = LAT_DEF;
        return c;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.pin  = 1'b0;
        st_d.pout = 1'b0;
        if (wr) begin
            case (code)
                RQ_RESET: begin
                    if (val == 16'd0) begin
                        st_d.pin        = 1'b1;
                        st_d.pout       = 1'b1;
                        st_d.cfg.evt    = EVT_DEF;
                        st_d.cfg.evt_en = 1'b0;
                        st_d.cfg.flow   = 3'b000;
                        st_d.cfg.dtr    = 1'b0;
                        st_d.cfg.rts    = 1'b0;
                    end else if (val == 16'd1) begin
                        st_d.pout = 1'b1;
                    end else begin
                        st_d.pin = 1'b1;
                    end
                end
                RQ_MODEM: begin
                    if (val[8]) st_d.cfg.dtr = val[0];
                    if (val[9]) st_d.cfg.rts = val[1];
                end
                RQ_FLOW: begin
                    st_d.cfg.xon  = val[7:0];
                    st_d.cfg.xoff = val[15:8];
                    st_d.cfg.flow = flow_in;
                end
                RQ_BAUD:  st_d.cfg.baud = {baud_hi, val};
                RQ_FMT: begin
                    st_d.cfg.dbits = val[7:0];
                    st_d.cfg.par   = val[10:8];
                    st_d.cfg.stop  = val[13:11];
                    st_d.cfg.brk   = val[14];
                end
                RQ_EVT: begin
                    st_d.cfg.evt    = val[7:0];
                    st_d.cfg.evt_en = val[8];
                end
                RQ_ERR: begin
                    st_d.cfg.err    = val[7:0];
                    st_d.cfg.err_en = val[8];
                end
                RQ_LATW:
                    st_d.cfg.lat = (val >= 16'(LAT_MIN) && val <= 16'd255) ? val[7:0] : LAT_MIN;
                RQ_BMODE: begin
                    st_d.cfg.bmode = val[15:8];
                    st_d.cfg.bmask = val[7:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= cfg_reset();
            st_q.pin  <= 1'b0;
            st_q.pout <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg       = st_q.cfg;
    assign purge_in  = st_q.pin;
    assign purge_out = st_q.pout;

    assert_lat_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.lat >= LAT_MIN);
    assert_masked_dtr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && code == RQ_MODEM && !val[8]) |=> $stable(st_q.cfg.dtr));
    assert_masked_rts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && code == RQ_MODEM && !val[9]) |=> $stable(st_q.cfg.rts));
    assert_full_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && code == RQ_RESET && val == 16'd0) |=>
            (!st_q.cfg.dtr && !st_q.cfg.rts && st_q.cfg.evt == EVT_DEF && purge_in && purge_out));

endmodule

// File: rtl/usbctl_vreq.sv
module usbctl_vreq
    import usbctl_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_vld,
    input  logic [7:0]           req_type,
    input  logic [7:0]           req_code,
    input  logic [15:0]          req_val,
    input  logic [15:0]          req_idx,
    input  logic [4*NUM_CH-1:0]  modem_in,
    input  logic [8*NUM_CH-1:0]  line_stat,
    input  logic [8*NUM_CH-1:0]  pin_in,
    output logic                 resp_vld,
    output logic                 resp_stall,
    output logic [1:0]           resp_len,
    output logic [15:0]          resp_data,
    output logic [NUM_CH-1:0]    purge_in,
    output logic [NUM_CH-1:0]    purge_out,
    output logic [NUM_CH-1:0]    modem_dtr,
    output logic [NUM_CH-1:0]    modem_rts,
    output logic [3*NUM_CH-1:0]  flow_mode,
    output logic [8*NUM_CH-1:0]  xon_char,
    output logic [8*NUM_CH-1:0]  xoff_char,
    output logic [8*NUM_CH-1:0]  data_bits,
    output logic [3*NUM_CH-1:0]  parity_sel,
    output logic [3*NUM_CH-1:0]  stop_sel,
    output logic [NUM_CH-1:0]    brk_on,
    output logic [8*NUM_CH-1:0]  evt_char,
    output logic [NUM_CH-1:0]    evt_en,
    output logic [8*NUM_CH-1:0]  err_char,
    output logic [NUM_CH-1:0]    err_en,
    output logic [8*NUM_CH-1:0]  lat_ms,
    output logic [8*NUM_CH-1:0]  bit_mode,
    output logic [8*NUM_CH-1:0]  bit_mask,
    output logic [18*NUM_CH-1:0] baud_div,
    output logic [NUM_CH-1:0]    ee_wr_en
);
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic        vld;
        logic        stall;
        logic [1:0]  len;
        logic [15:0] data;
    } resp_t;

    logic              dec_good, dec_stall;
    logic [NUM_CH-1:0] wr_sel;
    logic [CW-1:0]     ch_num;
    logic [1:0]        baud_hi;
    chan_cfg_t         cfg [NUM_CH];
    resp_t             rsp_d, rsp_q;

    usbctl_decode #(.NUM_CH(NUM_CH)) u_dec (
        .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld),
        .req_type(req_type), .req_code(req_code), .req_val(req_val), .req_idx(req_idx),
        .good(dec_good), .stall(dec_stall), .wr_sel(wr_sel),
        .ch_num(ch_num), .baud_hi(baud_hi)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        usbctl_chan u_chan (
            .clk(clk), .rst_n(rst_n), .wr(wr_sel[g]),
            .code(req_code), .val(req_val), .flow_in(req_idx[10:8]), .baud_hi(baud_hi),
            .cfg(cfg[g]), .purge_in(purge_in[g]), .purge_out(purge_out[g])
        );
        assign modem_dtr[g]         = cfg[g].dtr;
        assign modem_rts[g]         = cfg[g].rts;
        assign flow_mode[g*3 +: 3]  = cfg[g].flow;
        assign xon_char[g*8 +: 8]   = cfg[g].xon;
        assign xoff_char[g*8 +: 8]  = cfg[g].xoff;
        assign data_bits[g*8 +: 8]  = cfg[g].dbits;
        assign parity_sel[g*3 +: 3] = cfg[g].par;
        assign stop_sel[g*3 +: 3]   = cfg[g].stop;
        assign brk_on[g]            = cfg[g].brk;
        assign evt_char[g*8 +: 8]   = cfg[g].evt;
        assign evt_en[g]            = cfg[g].evt_en;
        assign err_char[g*8 +: 8]   = cfg[g].err;
        assign err_en[g]            = cfg[g].err_en;
        assign lat_ms[g*8 +: 8]     = cfg[g].lat;
        assign bit_mode[g*8 +: 8]   = cfg[g].bmode;
        assign bit_mask[g*8 +: 8]   = cfg[g].bmask;
        assign baud_div[g*18 +: 18] = cfg[g].baud;
        assign ee_wr_en[g]          = (cfg[g].lat == LAT_KEY);
    end

    always_comb begin
        logic [3:0] ms;
        ms         = modem_in[ch_num*4 +: 4];
        rsp_d      = '0;
        rsp_d.vld  = setup_vld;
        rsp_d.stall = dec_stall;
        if (dec_good) begin
            case (req_code)
                RQ_MSTAT: begin
                    rsp_d.len  = 2'd2;
                    rsp_d.data = {line_stat[ch_num*8 +: 8], ms[3], ms[2], ms[1], ms[0], 4'b0001};
                end
                RQ_LATR: begin
                    rsp_d.len  = 2'd1;
                    rsp_d.data = {8'h00, cfg[ch_num].lat};
                end
                RQ_PINS: begin
                    rsp_d.len  = 2'd1;
                    rsp_d.data = {8'h00, pin_in[ch_num*8 +: 8]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign resp_vld   = rsp_q.vld;
    assign resp_stall = rsp_q.stall;
    assign resp_len   = rsp_q.len;
    assign resp_data  = rsp_q.data;

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        setup_vld |=> resp_vld);
    assert_stall_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_stall |-> (purge_in == '0 && purge_out == '0 && resp_len == 2'd0));
    assert_purge_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (purge_in != '0 || purge_out != '0) |-> resp_vld);

endmodule

// File: tb/sim_usbctl_vreq.sv
`timescale 1ns/1ps
module sim_usbctl_vreq;

    localparam int N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        vld0 = 1'b0, vld1 = 1'b0;
    logic [7:0]  ty = '0, cd = '0;
    logic [15:0] va = '0, ix = '0;
    logic [4*N-1:0] modem_in = '0;
    logic [8*N-1:0] line_stat = '0, pin_in = '0;

    logic          r_vld, r_stall;
    logic [1:0]    r_len;
    logic [15:0]   r_data;
    logic [N-1:0]  p_in, p_out, dtr, rts, brk, evten, erren, eewr;
    logic [3*N-1:0] flow, par, stp;
    logic [8*N-1:0] xon, xoff, dbits, evtc, errc, lat, bmode, bmask;
    logic [18*N-1:0] baud;

    usbctl_vreq #(.NUM_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .setup_vld(vld0), .req_type(ty), .req_code(cd),
        .req_val(va), .req_idx(ix), .modem_in(modem_in), .line_stat(line_stat), .pin_in(pin_in),
        .resp_vld(r_vld), .resp_stall(r_stall), .resp_len(r_len), .resp_data(r_data),
        .purge_in(p_in), .purge_out(p_out), .modem_dtr(dtr), .modem_rts(rts),
        .flow_mode(flow), .xon_char(xon), .xoff_char(xoff), .data_bits(dbits),
        .parity_sel(par), .stop_sel(stp), .brk_on(brk), .evt_char(evtc), .evt_en(evten),
        .err_char(errc), .err_en(erren), .lat_ms(lat), .bit_mode(bmode), .bit_mask(bmask),
        .baud_div(baud), .ee_wr_en(eewr)
    );

    logic        s_vld, s_stall, s_pi, s_po, s_dtr, s_rts, s_brk, s_ee, s_een, s_ern;
    logic [1:0]  s_len;
    logic [15:0] s_data;
    logic [2:0]  s_flow, s_par, s_stp;
    logic [7:0]  s_xon, s_xoff, s_db, s_evt, s_err, s_lat, s_bm, s_bk;
    logic [17:0] s_baud;

    usbctl_vreq #(.NUM_CH(1)) u1 (
        .clk(clk), .rst_n(rst_n), .setup_vld(vld1), .req_type(ty), .req_code(cd),
        .req_val(va), .req_idx(ix), .modem_in(4'h0), .line_stat(8'h00), .pin_in(8'h00),
        .resp_vld(s_vld), .resp_stall(s_stall), .resp_len(s_len), .resp_data(s_data),
        .purge_in(s_pi), .purge_out(s_po), .modem_dtr(s_dtr), .modem_rts(s_rts),
        .flow_mode(s_flow), .xon_char(s_xon), .xoff_char(s_xoff), .data_bits(s_db),
        .parity_sel(s_par), .stop_sel(s_stp), .brk_on(s_brk), .evt_char(s_evt), .evt_en(s_een),
        .err_char(s_err), .err_en(s_ern), .lat_ms(s_lat), .bit_mode(s_bm), .bit_mask(s_bk),
        .baud_div(s_baud), .ee_wr_en(s_ee)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive at negedge, result is registered at the next posedge, sampled at the following negedge
    task automatic send(input bit tgt, input logic [7:0] t, input logic [7:0] c,
                        input logic [15:0] v, input logic [15:0] i);
        @(negedge clk);
        ty = t; cd = c; va = v; ix = i;
        if (tgt) vld1 = 1'b1; else vld0 = 1'b1;
        @(negedge clk);
        vld0 = 1'b0; vld1 = 1'b0;
    endtask

    typedef struct packed {
        logic [7:0]  t;
        logic [7:0]  c;
        logic [15:0] v;
        logic [15:0] i;
        logic        st;
        logic [1:0]  ln;
        logic [15:0] d;
    } vec_t;

    localparam vec_t VT [15] = '{
        '{8'hC0, 8'h0A, 16'h0000, 16'h0001, 1'b0, 2'd1, 16'h0010}, // R8 default 16
        '{8'h40, 8'h09, 16'h0005, 16'h0001, 1'b0, 2'd0, 16'h0000},
        '{8'hC0, 8'h0A, 16'h0000, 16'h0001, 1'b0, 2'd1, 16'h0005},
        '{8'h40, 8'h09, 16'h0001, 16'h0001, 1'b0, 2'd0, 16'h0000}, // R8 clamp low
        '{8'hC0, 8'h0A, 16'h0000, 16'h0001, 1'b0, 2'd1, 16'h0002},
        '{8'h40, 8'h09, 16'h00FF, 16'h0001, 1'b0, 2'd0, 16'h0000},
        '{8'h40, 8'h09, 16'h0100, 16'h0001, 1'b0, 2'd0, 16'h0000}, // R8 clamp high
        '{8'hC0, 8'h0A, 16'h0000, 16'h0001, 1'b0, 2'd1, 16'h0002},
        '{8'h40, 8'h08, 16'h0030, 16'h0001, 1'b1, 2'd0, 16'h0000}, // R1 unknown
        '{8'hC0, 8'h09, 16'h0030, 16'h0001, 1'b1, 2'd0, 16'h0000}, // R1 direction
        '{8'h40, 8'h09, 16'h0030, 16'h0000, 1'b1, 2'd0, 16'h0000}, // R10 ch 0
        '{8'h40, 8'h09, 16'h0030, 16'h0003, 1'b1, 2'd0, 16'h0000}, // R10 ch 3
        '{8'hC0, 8'h0A, 16'h0000, 16'h0001, 1'b0, 2'd1, 16'h0002}, // R1 untouched
        '{8'hC0, 8'h0A, 16'h0000, 16'h0002, 1'b0, 2'd1, 16'h0010}, // R10 ch2 separate
        '{8'h40, 8'h00, 16'h0003, 16'h0001, 1'b1, 2'd0, 16'h0000}  // R1 reset kind 3
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 resp_vld", r_vld, 0);
        chk("R13 purge", {p_in, p_out}, 0);
        chk("R13 dtr/rts", {dtr[0], rts[0]}, 0);
        chk("R13 data bits", dbits[7:0], 8'd8);
        chk("R13 evt", {evten[0], evtc[7:0]}, {1'b0, 8'h0D});
        chk("R13 latency", lat[15:8], 8'd16);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 15; k++) begin
            send(0, VT[k].t, VT[k].c, VT[k].v, VT[k].i);
            chk($sformatf("R2 vec%0d vld", k), r_vld, 1);
            chk($sformatf("R1 vec%0d stall", k), r_stall, VT[k].st);
            chk($sformatf("R2 vec%0d len", k), r_len, VT[k].ln);
            if (VT[k].ln != 0) chk($sformatf("R2 vec%0d data", k), r_data, VT[k].d);
        end
        @(negedge clk);
        chk("R2 resp drops", r_vld, 0);

        // R2 status and pin reads, channel 1
        modem_in  = 8'h0A;
        line_stat = 16'h0060;
        pin_in    = 16'h335A;
        send(0, 8'hC0, 8'h05, 16'h0, 16'h0001);
        chk("R2 modem status", {r_len, r_data}, {2'd2, 16'h60A1});
        send(0, 8'hC0, 8'h0C, 16'h0, 16'h0001);
        chk("R2 pin state ch1", {r_len, r_data}, {2'd1, 16'h005A});
        send(0, 8'hC0, 8'h0C, 16'h0, 16'h0002);
        chk("R2 pin state ch2", r_data, 16'h0033);

        // R3 masked modem control
        send(0, 8'h40, 8'h01, 16'h0303, 16'h0001);
        chk("R3 both set", {dtr[0], rts[0]}, 2'b11);
        send(0, 8'h40, 8'h01, 16'h0100, 16'h0001);
        chk("R3 dtr only", {dtr[0], rts[0]}, 2'b01);
        send(0, 8'h40, 8'h01, 16'h0003, 16'h0001);
        chk("R3 no change bits", {dtr[0], rts[0]}, 2'b01);
        send(0, 8'h40, 8'h01, 16'h0200, 16'h0001);
        chk("R3 rts only", {dtr[0], rts[0]}, 2'b00);
        send(0, 8'h40, 8'h01, 16'h0301, 16'h0001);

        // R4 flow control
        send(0, 8'h40, 8'h02, 16'h1311, 16'h0501);
        chk("R4 flow", {flow[2:0], xon[7:0], xoff[7:0]}, {3'b101, 8'h11, 8'h13});
        chk("R4 ch2 untouched", flow[5:3], 3'b000);

        // R5 data format
        send(0, 8'h40, 8'h04, 16'h5207, 16'h0001);
        chk("R5 format", {dbits[7:0], par[2:0], stp[2:0], brk[0]}, {8'd7, 3'd2, 3'd2, 1'b1});

        // R6 event and error characters
        send(0, 8'h40, 8'h06, 16'h017E, 16'h0001);
        chk("R6 event", {evten[0], evtc[7:0]}, {1'b1, 8'h7E});
        send(0, 8'h40, 8'h07, 16'h0124, 16'h0001);
        chk("R6 error", {erren[0], errc[7:0]}, {1'b1, 8'h24});

        // R12 bit mode
        send(0, 8'h40, 8'h0B, 16'h04F0, 16'h0002);
        chk("R12 bit mode", {bmode[15:8], bmask[15:8]}, {8'h04, 8'hF0});

        // R11 baud, multi-channel
        send(0, 8'h40, 8'h03, 16'hC002, 16'h0301);
        chk("R11 baud multi", baud[17:0], 18'h3C002);

        // R7 reset kinds
        send(0, 8'h40, 8'h00, 16'h0001, 16'h0001);
        chk("R7 kind1 purge", {p_in[0], p_out[0]}, 2'b01);
        chk("R7 kind1 keeps dtr", dtr[0], 1);
        send(0, 8'h40, 8'h00, 16'h0002, 16'h0001);
        chk("R7 kind2 purge", {p_in[0], p_out[0]}, 2'b10);
        send(0, 8'h40, 8'h00, 16'h0000, 16'h0001);
        chk("R7 kind0 purge", {p_in, p_out}, 4'b0101);
        chk("R7 kind0 defaults", {dtr[0], rts[0], flow[2:0], evten[0], evtc[7:0]},
            {2'b00, 3'b000, 1'b0, 8'h0D});
        chk("R7 kind0 keeps err", {erren[0], errc[7:0], dbits[7:0]}, {1'b1, 8'h24, 8'd7});
        @(negedge clk);
        chk("R7 purge one cycle", {p_in, p_out}, 0);

        // R9 unlock
        send(0, 8'h40, 8'h09, 16'h0077, 16'h0001);
        chk("R9 unlocked", eewr, 2'b01);
        send(0, 8'h40, 8'h09, 16'h0076, 16'h0001);
        chk("R9 relocked", eewr, 2'b00);

        // R10 / R11 single-channel build
        send(1, 8'h40, 8'h09, 16'h0044, 16'h0000);
        chk("R10 single ch0 ok", {s_stall, s_lat}, {1'b0, 8'h44});
        send(1, 8'h40, 8'h09, 16'h0055, 16'h0001);
        chk("R10 single ch1 stall", {s_stall, s_lat}, {1'b1, 8'h44});
        send(1, 8'h40, 8'h03, 16'h1234, 16'h0002);
        chk("R11 baud single", {s_stall, s_baud}, {1'b0, 18'h21234});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule